// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast oscillator clock by a programmable total ratio of P·B + A. It does this by steering a dual-modulus prescaler with two down-counters. The swallow counter holds the prescaler at modulus P+1 for the first A prescaler periods of each output cycle. After that, the prescaler runs at modulus P until the main counter has seen B prescaler periods. The block then emits a one-cycle pulse to the phase detector and reloads both counters.

A select bit picks the prescaler pair. When it is 1 the pair is P_SMALL/P_SMALL+1 (default 64/65). When it is 0 the pair is P_LARGE/P_LARGE+1 (default 128/129). For simulation the prescaler is a synthesizable counter clocked by the fast input clock, so the whole block runs in that one clock domain.

The A value, the B value and the select bit are sampled only at reset and at each reload boundary. A divide cycle already under way is therefore never disturbed by new settings. Legal settings are 3 ≤ B ≤ 2047, 0 ≤ A ≤ 127 and A ≤ B.

Top module: `psd_divider`

## Requirements
- R1: With `pre_sel_small`=1, consecutive `div_out` pulses are exactly P_SMALL·B + A input clock cycles apart.
- R2: With `pre_sel_small`=0, consecutive `div_out` pulses are exactly P_LARGE·B + A input clock cycles apart.
- R3: `div_out` is high for exactly one input clock cycle per output period.
- R4: In each output period `mod_ctl` (1 = prescaler divides by P+1) is high for exactly A·(P+1) input cycles and low for the rest.
- R5: With A = 0, `mod_ctl` stays low for the whole period and the ratio is P·B.
- R6: With A = B, `mod_ctl` stays high for the whole period and the ratio is (P+1)·B.
- R7: After synchronous reset is released, the first `div_out` pulse is seen after exactly P·B + A rising edges.
- R8: A, B and the select bit changed in the middle of a period take effect only from the next reload, so the period under way keeps the old ratio and `mod_ctl` count.
- R9: While reset is held, `div_out` is low and `mod_ctl` is high exactly when the applied A is nonzero.
- R10: The minimum main count B = 3 divides correctly, and the main counter never holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast input clock (oscillator side) |
| rst_n | input | 1 | Synchronous active-low reset; also loads the settings |
| swallow_val | input | A_W | Swallow count A |
| main_val | input | B_W | Main count B (3 or more) |
| pre_sel_small | input | 1 | 1 selects the P_SMALL pair, 0 selects the P_LARGE pair |
| mod_ctl | output | 1 | Modulus control; 1 = divide by P+1 |
| div_out | output | 1 | One-cycle pulse per output period, to the phase detector |

## Verification
Both outputs are registered. `div_out` rises on the same edge that reloads the counters. So the N-th rising edge after reset release, or after the previous pulse, is the one that brings the pulse. The bench drives inputs and samples outputs at falling edges and counts rising edges between samples of `div_out`, so each measured interval is exactly the ratio. `mod_ctl` is sampled once per cycle across the same window, and that count is compared with A·(P+1). Because the reload happens on the pulse edge, settings changed right after a pulse is sampled must show up only in the interval after the next one.

// File: rtl/psd_pkg.sv
// Package: shared defaults for the pulse-swallow divider.
// Assumes the prescaler pair values are powers of two or any value >= 4.
package psd_pkg;
    localparam int A_W_DEF     = 7;
    localparam int B_W_DEF     = 11;
    localparam int P_SMALL_DEF = 64;
    localparam int P_LARGE_DEF = 128;
endpackage

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler model: emits a one-cycle tick every P or P+1
// input cycles. Assumes sel_small and mod_hi change only on tick edges.
module psd_prescaler #(
    parameter int P_SMALL = 64,
    parameter int P_LARGE = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_small,
    input  logic mod_hi,
    output logic tick
);
    localparam int CW = $clog2(P_LARGE + 2);
    localparam logic [CW-1:0] LAST_SMALL = CW'(P_SMALL - 1);
    localparam logic [CW-1:0] LAST_LARGE = CW'(P_LARGE - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_val;

    // Pick the terminal count for the current modulus.
    always_comb begin
        last_val = sel_small ? LAST_SMALL : LAST_LARGE;
        if (mod_hi) last_val = last_val + CW'(1);
    end

    assign tick = (cnt == last_val);

    // Count input cycles and wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + CW'(1);
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(P_LARGE));
endmodule

// File: rtl/psd_swallow_ctr.sv
// Swallow counter: holds modulus control high for the first A prescaler
// periods after each reload. Assumes A <= B so it empties before reload.
module psd_swallow_ctr #(
    parameter int A_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           reload,
    input  logic [A_W-1:0] a_load,
    output logic           mod_hi
);
    logic [A_W-1:0] a_cnt;

    // Load at reset or reload, count down once per prescaler period.
    always_ff @(posedge clk) begin
        if (!rst_n)                    a_cnt <= a_load;
        else if (reload)               a_cnt <= a_load;
        else if (tick && a_cnt != '0)  a_cnt <= a_cnt - A_W'(1);
    end

    assign mod_hi = (a_cnt != '0);

    // R4
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(a_cnt));
endmodule

// File: rtl/psd_main_ctr.sv
// Main counter: counts B prescaler periods and flags the last one.
// Assumes B >= 3; the flag doubles as the reload strobe for the block.
module psd_main_ctr #(
    parameter int B_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [B_W-1:0] b_load,
    output logic           wrap
);
    logic [B_W-1:0] b_cnt;

    assign wrap = tick && (b_cnt == B_W'(1));

    // Load at reset or wrap, count down once per prescaler period.
    always_ff @(posedge clk) begin
        if (!rst_n)     b_cnt <= b_load;
        else if (wrap)  b_cnt <= b_load;
        else if (tick)  b_cnt <= b_cnt - B_W'(1);
    end

    // R10
    b_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_cnt != '0);
endmodule

// File: rtl/psd_divider.sv
// Top: pulse-swallow divider with prescaler model. Divides clk_vco by
// P*B + A. Settings are sampled only at reset and at each reload.
module psd_divider
    import psd_pkg::*;
#(
    parameter int A_W     = A_W_DEF,
    parameter int B_W     = B_W_DEF,
    parameter int P_SMALL = P_SMALL_DEF,
    parameter int P_LARGE = P_LARGE_DEF
) (
    input  logic           clk_vco,
    input  logic           rst_n,
    input  logic [A_W-1:0] swallow_val,
    input  logic [B_W-1:0] main_val,
    input  logic           pre_sel_small,
    output logic           mod_ctl,
    output logic           div_out
);
    logic pre_tick;
    logic wrap;
    logic sel_q;

    // Latch the prescaler pair choice at the reload boundary only.
    always_ff @(posedge clk_vco) begin
        if (!rst_n || wrap) sel_q <= pre_sel_small;
    end

    // Register the output pulse on the reload edge.
    always_ff @(posedge clk_vco) begin
        if (!rst_n) div_out <= 1'b0;
        else        div_out <= wrap;
    end

    psd_prescaler #(.P_SMALL(P_SMALL), .P_LARGE(P_LARGE)) pre_i (
        .clk(clk_vco), .rst_n(rst_n), .sel_small(sel_q),
        .mod_hi(mod_ctl), .tick(pre_tick));

    psd_swallow_ctr #(.A_W(A_W)) swl_i (
        .clk(clk_vco), .rst_n(rst_n), .tick(pre_tick), .reload(wrap),
        .a_load(swallow_val), .mod_hi(mod_ctl));

    psd_main_ctr #(.B_W(B_W)) main_i (
        .clk(clk_vco), .rst_n(rst_n), .tick(pre_tick),
        .b_load(main_val), .wrap(wrap));

    // R3
    pulse_width_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        div_out |=> !div_out);

    // R4
    mod_fall_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
        $fell(mod_ctl) |-> $past(pre_tick));
endmodule

// File: tb/psd_divider_tb.sv
// Bench for psd_divider: table-driven ratio checks, then reset and
// mid-period update tests.
module psd_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  a_v = '0;
    logic [10:0] b_v = 11'd3;
    logic        sel = 1'b1;
    logic        mod_ctl, div_out;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc_total = 0;

    always #4 clk = ~clk;

    psd_divider dut_i (
        .clk_vco(clk), .rst_n(rst_n), .swallow_val(a_v), .main_val(b_v),
        .pre_sel_small(sel), .mod_ctl(mod_ctl), .div_out(div_out));

    // Vector: {select, A, B}
    localparam logic [18:0] VEC [9] = '{
        {1'b1, 7'd0,   11'd3},
        {1'b1, 7'd3,   11'd3},
        {1'b0, 7'd0,   11'd3},
        {1'b0, 7'd2,   11'd5},
        {1'b1, 7'd5,   11'd10},
        {1'b0, 7'd7,   11'd9},
        {1'b1, 7'd1,   11'd4},
        {1'b1, 7'd127, 11'd127},
        {1'b0, 7'd10,  11'd20}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count rising edges until div_out is seen high at a falling edge.
    task automatic wait_pulse(output int cyc, output int hi, output bit first_hi);
        cyc = 0; hi = 0; first_hi = 1'b0;
        forever begin
            @(posedge clk); @(negedge clk);
            cyc++;
            if (mod_ctl) hi++;
            if (cyc == 1) first_hi = div_out;
            if (div_out || cyc > 20000) break;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 190000) begin
            n_err++; n_chk++;
            $display("FAIL R1 watchdog actual=%0d expected=<190000", cyc_total);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int n, h, p, exp_n;
        bit w;
        // R9: reset state with nonzero and zero A
        a_v = 7'd5; b_v = 11'd8; sel = 1'b1; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(div_out == 1'b0, "R9 div_out in reset", int'(div_out), 0);
        check(mod_ctl == 1'b1, "R9 mod_ctl in reset A=5", int'(mod_ctl), 1);
        a_v = 7'd0;
        @(negedge clk); @(negedge clk);
        check(mod_ctl == 1'b0, "R9 mod_ctl in reset A=0", int'(mod_ctl), 0);

        for (int i = 0; i < 9; i++) begin
            sel = VEC[i][18]; a_v = VEC[i][17:11]; b_v = VEC[i][10:0];
            p = sel ? 64 : 128;
            exp_n = p * int'(b_v) + int'(a_v);
            do_reset();
            wait_pulse(n, h, w);
            check(n == exp_n, "R7 first pulse after reset", n, exp_n);
            wait_pulse(n, h, w);
            // R1 / R2 (R10 covered by B=3 rows)
            check(n == exp_n, sel ? "R1 period small pair" : "R2 period large pair", n, exp_n);
            check(w == 1'b0, "R3 pulse width", int'(w), 0);
            if (a_v == 0)
                check(h == 0, "R5 mod_ctl low with A=0", h, 0);
            else if (int'(a_v) == int'(b_v))
                check(h == exp_n, "R6 mod_ctl high with A=B", h, exp_n);
            else
                check(h == int'(a_v) * (p + 1), "R4 mod_ctl high count", h, int'(a_v) * (p + 1));
        end

        // R10: minimum B with A=1, large pair
        sel = 1'b0; a_v = 7'd1; b_v = 11'd3;
        do_reset();
        wait_pulse(n, h, w);
        wait_pulse(n, h, w);
        check(n == 385, "R10 B=3 ratio", n, 385);

        // R8: change settings right after a reload
        sel = 1'b1; a_v = 7'd2; b_v = 11'd4;
        do_reset();
        wait_pulse(n, h, w);
        sel = 1'b0; a_v = 7'd1; b_v = 11'd3;
        wait_pulse(n, h, w);
        check(n == 258, "R8 old ratio kept", n, 258);
        check(h == 130, "R8 old mod_ctl count kept", h, 130);
        wait_pulse(n, h, w);
        check(n == 385, "R8 new ratio applied", n, 385);
        check(h == 129, "R8 new mod_ctl count", h, 129);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule